// File: doc/BRIEF.md
# Wired-Interrupt to Message Converter

This block takes a bank of level or edge interrupt wires and turns each one into a message-signalled interrupt write. The pins are organised into nodes of 128 pins each. A 32-bit register port holds, for each node, a bitmap that picks the trigger mode and one vector register per pin. The vector register carries the event identifier that software programs and the device identifier that the hardware fixes. When a pin's trigger condition occurs it becomes pending. The block then sends exactly one message for it on a valid/ready request port, with the fixed doorbell address, the pin's device ID and its event ID.

A pending pin stays pending and silent until software writes a one to its bit in a shared clear page. Reading that page returns the pending bits. Global pin numbers start at 64, because numbers 0 to 63 are reserved. Input wire `irq_pins[i]` is global pin `64+i`, which sits in node `i/128+1` at local pin `i%128`. The node count is a parameter, so a small build can be used.

Top module: `wirq_msg_bridge`

## Requirements
- R1: The vector register of global pin g is at node*0x1000 + 0x200 + local*4, where node = (g-64)/128+1 and local = (g-64)%128. It reads back with the event ID in bits [21:12], the device ID DEVID_BASE+node in bits [11:0] and zeros in bits [31:22]. After reset the event ID equals the local pin number.
- R2: A write to a vector register changes only bits [21:12]. The device ID and bits [31:22] read back unchanged, whatever the written data holds.
- R3: The trigger-type word for a local pin is at node*0x1000 + (local/32)*4, with the pin at bit local%32. It reads back what was written and resets to all zeros.
- R4: With a type bit of 0 the pin triggers on a 0-to-1 transition of its wire. A wire held high does not trigger again after the pin is cleared.
- R5: With a type bit of 1 the pin triggers while its wire is high. If the wire is still high when the pin is cleared, the pin becomes pending again and sends a new message.
- R6: A pending pin sends exactly one message. Further triggers before its clear produce no message, and the pin stays pending until it is cleared.
- R7: The clear page word for global pin g is at 0xA000 + (g/32)*4, with the pin at bit g%32. A read returns the pending bits. Writing 1 clears that pin and writing 0 has no effect. Bits for pins 0..63 read zero and ignore writes.
- R8: When several pins are pending and unsent, the lowest-numbered pin is sent first.
- R9: A message carries the pin's device ID and the event ID in effect when it is sent, together with the fixed DOORBELL address. It holds stable while msg_valid is high and msg_ready is low.
- R10: Reads of unmapped addresses return zero and writes to them have no effect. Unmapped addresses include node 0, nodes above NODES, gaps inside a node window and clear words beyond the last pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pins | input | NODES*128 | Wired interrupts; bit i is global pin 64+i |
| csr_en | input | 1 | Register access strobe |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 16 | Byte address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_addr | output | 64 | Doorbell address (constant) |
| msg_dev_id | output | 12 | Device ID of the message |
| msg_event_id | output | 10 | Event ID of the message |

## Verification
The hardest cases to produce are the ones where a pin's clear and its own trigger meet. One is a level pin cleared while its wire is still high. The other is an edge pin re-pulsed while it is already pending. Both need the bench to hold a wire and write the clear page at the right point after a message has been accepted. The bench does this pin by pin across every pin of a two-node build. It re-pulses each pin after its message and then clears it. It also holds selected pins high through a clear in both trigger modes, and it raises a scattered set of pins in the same cycle to observe the dispatch order.

// File: rtl/wirq_pkg.sv
package wirq_pkg;
  localparam int PINS_PER_NODE = 128;
  localparam int RSVD_PINS     = 64;
  localparam int EVT_W         = 10;
  localparam int DEV_W         = 12;
  localparam logic [3:0] CLR_PAGE = 4'hA;

  // node number (1-based) of a pin index counted from the first usable pin
  function automatic int node_of_idx(input int idx);
    return idx / PINS_PER_NODE + 1;
  endfunction

  function automatic logic [DEV_W-1:0] dev_of_node(input logic [DEV_W-1:0] base,
                                                   input int node);
    return base + DEV_W'(node);
  endfunction

  function automatic logic [EVT_W-1:0] evt_reset(input int idx);
    return EVT_W'(idx % PINS_PER_NODE);
  endfunction
endpackage

// File: rtl/wirq_regs.sv
module wirq_regs
  import wirq_pkg::*;
#(
  parameter int NODES = 2,
  parameter logic [DEV_W-1:0] DEVID_BASE = 12'h140
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          csr_en,
  input  logic                          csr_we,
  input  logic [15:0]                   csr_addr,
  input  logic [31:0]                   csr_wdata,
  input  logic [NODES*PINS_PER_NODE-1:0] pend,
  output logic [31:0]                   csr_rdata,
  output logic [NODES*PINS_PER_NODE-1:0] level_sel,
  output logic [NODES*PINS_PER_NODE*EVT_W-1:0] evt_flat,
  output logic [NODES*PINS_PER_NODE-1:0] clr_vec
);
  localparam int NPINS     = NODES * PINS_PER_NODE;
  localparam int IW        = $clog2(NPINS);
  localparam int PADW      = RSVD_PINS + NPINS;
  localparam int CLR_WORDS = PADW / 32;

  logic [3:0]  a_page;
  logic [11:0] a_off;
  int          page_i, cword, tbase, vidx;
  logic [IW-1:0] vidx_w;
  logic        hit_clr, node_ok, hit_type, hit_vec, wr;

  // address decode; the clear page takes priority over a node page
  always_comb begin
    a_page   = csr_addr[15:12];
    a_off    = csr_addr[11:0];
    page_i   = int'(a_page);
    cword    = int'(csr_addr[11:2]);
    hit_clr  = (a_page == CLR_PAGE) && (cword < CLR_WORDS);
    node_ok  = !hit_clr && (page_i >= 1) && (page_i <= NODES);
    hit_type = node_ok && (a_off[11:4] == 8'h00);
    hit_vec  = node_ok && (a_off[11:9] == 3'b001);
    tbase    = (page_i - 1) * PINS_PER_NODE + int'(a_off[3:2]) * 32;
    vidx     = (page_i - 1) * PINS_PER_NODE + int'(a_off[8:2]);
    vidx_w   = IW'(vidx);
  end

  assign wr = csr_en && csr_we;

  logic [NPINS-1:0] type_q;
  logic [EVT_W-1:0] evt_q [NPINS];

  always_ff @(posedge clk) begin
    if (!rst_n) type_q <= '0;
    else if (wr && hit_type) type_q[tbase +: 32] <= csr_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) evt_q[i] <= evt_reset(i);
    end else if (wr && hit_vec) begin
      evt_q[vidx_w] <= csr_wdata[21:12];
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_evt
    assign evt_flat[g*EVT_W +: EVT_W] = evt_q[g];
  end
  assign level_sel = type_q;

  // clear page: reserved pins are padded in as zeros
  logic [PADW-1:0] pend_pad, clr_pad;
  assign pend_pad = {pend, {RSVD_PINS{1'b0}}};

  always_comb begin
    clr_pad = '0;
    if (wr && hit_clr) clr_pad[cword*32 +: 32] = csr_wdata;
  end
  assign clr_vec = clr_pad[PADW-1:RSVD_PINS];

  logic [31:0] rd_next, rdata_q;
  always_comb begin
    rd_next = '0;
    if (hit_clr)       rd_next = pend_pad[cword*32 +: 32];
    else if (hit_type) rd_next = type_q[tbase +: 32];
    else if (hit_vec)  rd_next = {10'b0, evt_q[vidx_w], dev_of_node(DEVID_BASE, page_i)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (csr_en && !csr_we) rdata_q <= rd_next;
  end
  assign csr_rdata = rdata_q;
endmodule

// File: rtl/wirq_pend.sv
module wirq_pend #(
  parameter int NPINS = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] irq_pins,
  input  logic [NPINS-1:0] level_sel,
  input  logic [NPINS-1:0] clr_vec,
  input  logic [NPINS-1:0] load_vec,
  output logic [NPINS-1:0] trig_vec,
  output logic [NPINS-1:0] pend,
  output logic [NPINS-1:0] sent
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic prev_q, pend_q, sent_q;
    assign trig_vec[g] = level_sel[g] ? irq_pins[g] : (irq_pins[g] & ~prev_q);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
        sent_q <= 1'b0;
      end else begin
        prev_q <= irq_pins[g];
        // a trigger in the clearing cycle wins, and the pin goes out again
        pend_q <= (pend_q & ~clr_vec[g]) | trig_vec[g];
        sent_q <= (sent_q | load_vec[g]) & ~clr_vec[g];
      end
    end
    assign pend[g] = pend_q;
    assign sent[g] = sent_q;
  end
endmodule

// File: rtl/wirq_arb.sv
module wirq_arb
  import wirq_pkg::*;
#(
  parameter int NODES = 2,
  parameter logic [DEV_W-1:0] DEVID_BASE = 12'h140,
  parameter int NPINS = NODES * PINS_PER_NODE,
  parameter int IW = $clog2(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pend,
  input  logic [NPINS-1:0]       sent,
  input  logic [NPINS*EVT_W-1:0] evt_flat,
  input  logic                   msg_ready,
  output logic [NPINS-1:0]       cand,
  output logic [NPINS-1:0]       load_vec,
  output logic                   msg_valid,
  output logic [IW-1:0]          msg_pin,
  output logic [DEV_W-1:0]       msg_dev,
  output logic [EVT_W-1:0]       msg_evt
);
  function automatic logic [IW-1:0] lowest(input logic [NPINS-1:0] v);
    lowest = '0;
    for (int i = NPINS - 1; i >= 0; i--) if (v[i]) lowest = IW'(i);
  endfunction

  logic [IW-1:0] pick;
  logic          load, valid_q;

  assign cand     = pend & ~sent;
  assign pick     = lowest(cand);
  assign load     = !valid_q && (|cand);
  assign load_vec = load ? (NPINS'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      msg_pin <= '0;
      msg_dev <= '0;
      msg_evt <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      msg_pin <= pick;
      msg_dev <= dev_of_node(DEVID_BASE, node_of_idx(int'(pick)));
      msg_evt <= evt_flat[int'(pick)*EVT_W +: EVT_W];
    end else if (valid_q && msg_ready) begin
      valid_q <= 1'b0;
    end
  end
  assign msg_valid = valid_q;
endmodule

// File: rtl/wirq_msg_bridge.sv
module wirq_msg_bridge
  import wirq_pkg::*;
#(
  parameter int NODES = 2,
  parameter logic [11:0] DEVID_BASE = 12'h140,
  parameter logic [63:0] DOORBELL = 64'h0000_0000_3FFF_0040
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NODES*128-1:0]          irq_pins,
  input  logic                          csr_en,
  input  logic                          csr_we,
  input  logic [15:0]                   csr_addr,
  input  logic [31:0]                   csr_wdata,
  output logic [31:0]                   csr_rdata,
  output logic                          msg_valid,
  input  logic                          msg_ready,
  output logic [63:0]                   msg_addr,
  output logic [11:0]                   msg_dev_id,
  output logic [9:0]                    msg_event_id
);
  localparam int NPINS = NODES * PINS_PER_NODE;
  localparam int IW    = $clog2(NPINS);

  logic [NPINS-1:0]       pend, sent, trig_vec, clr_vec, level_sel, load_vec, cand;
  logic [NPINS*EVT_W-1:0] evt_flat;
  logic [IW-1:0]          msg_pin;

  wirq_regs #(.NODES(NODES), .DEVID_BASE(DEVID_BASE)) regs_i (
    .clk, .rst_n, .csr_en, .csr_we, .csr_addr, .csr_wdata,
    .pend, .csr_rdata, .level_sel, .evt_flat, .clr_vec
  );

  wirq_pend #(.NPINS(NPINS)) pend_i (
    .clk, .rst_n, .irq_pins, .level_sel, .clr_vec, .load_vec,
    .trig_vec, .pend, .sent
  );

  wirq_arb #(.NODES(NODES), .DEVID_BASE(DEVID_BASE), .NPINS(NPINS), .IW(IW)) arb_i (
    .clk, .rst_n, .pend, .sent, .evt_flat, .msg_ready,
    .cand, .load_vec, .msg_valid, .msg_pin,
    .msg_dev(msg_dev_id), .msg_evt(msg_event_id)
  );

  assign msg_addr = DOORBELL;
endmodule

// File: rtl/wirq_chk.sv
module wirq_chk #(
  parameter int NPINS = 256,
  parameter int IW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pend,
  input logic [NPINS-1:0] sent,
  input logic [NPINS-1:0] trig_vec,
  input logic [NPINS-1:0] clr_vec,
  input logic [NPINS-1:0] cand,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [IW-1:0]    msg_pin,
  input logic [11:0]      msg_dev_id,
  input logic [9:0]       msg_event_id
);
  function automatic logic [NPINS-1:0] below(input logic [IW-1:0] p);
    return (NPINS'(1) << p) - NPINS'(1);
  endfunction

  // R9: payload held while the request waits
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_pin)
      && $stable(msg_dev_id) && $stable(msg_event_id)));

  // R7: a cleared pin without a fresh trigger is no longer pending
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~trig_vec)) |=> ((pend & $past(clr_vec & ~trig_vec)) == '0));

  // R6: pending is kept until a clear
  a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |=> ((~pend & $past(pend & ~clr_vec)) == '0));

  // R6: a pin marked as sent is still pending
  a_r6_sent_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|sent) |-> ((sent & ~pend) == '0));

  // R8: a new message is for the lowest waiting pin
  a_r8_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> ((($past(cand) & below(msg_pin)) == '0)
      && ((($past(cand) >> msg_pin) & NPINS'(1)) == NPINS'(1))));
endmodule

bind wirq_msg_bridge wirq_chk #(.NPINS(NPINS), .IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .pend(pend), .sent(sent), .trig_vec(trig_vec),
  .clr_vec(clr_vec), .cand(cand), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_pin(msg_pin), .msg_dev_id(msg_dev_id), .msg_event_id(msg_event_id)
);

// File: tb/wirq_msg_bridge_tb_top.sv
`timescale 1ns/1ps
module wirq_msg_bridge_tb_top;
  localparam int NODES = 2;
  localparam int NP = NODES * 128;
  localparam logic [11:0] DEVB = 12'h140;
  localparam logic [63:0] DBELL = 64'h0000_0000_3FFF_0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] irq_pins = '0;
  logic csr_en = 1'b0, csr_we = 1'b0, msg_ready = 1'b0;
  logic [15:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic msg_valid;
  logic [63:0] msg_addr;
  logic [11:0] msg_dev_id;
  logic [9:0] msg_event_id;

  always #2.5 clk = ~clk;

  wirq_msg_bridge #(.NODES(NODES), .DEVID_BASE(DEVB), .DOORBELL(DBELL)) dut_i (
    .clk, .rst_n, .irq_pins, .csr_en, .csr_we, .csr_addr, .csr_wdata, .csr_rdata,
    .msg_valid, .msg_ready, .msg_addr, .msg_dev_id, .msg_event_id
  );

  int compared = 0, mismatched = 0;
  logic [9:0] evt_model [NP];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_a(input int i);
    return 16'((i/128 + 1)*4096 + 'h200 + (i%128)*4);
  endfunction
  function automatic logic [15:0] type_a(input int i);
    return 16'((i/128 + 1)*4096 + ((i%128)/32)*4);
  endfunction
  function automatic logic [15:0] clr_a(input int i);
    return 16'('hA000 + ((i+64)/32)*4);
  endfunction
  function automatic logic [31:0] clr_bit(input int i);
    return 32'(1) << ((i+64) % 32);
  endfunction
  function automatic logic [11:0] dev_of(input int i);
    return DEVB + 12'(i/128 + 1);
  endfunction

  task automatic csr_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_en = 0; csr_we = 0;
  endtask

  task automatic csr_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); csr_en = 1; csr_we = 0; csr_addr = a;
    @(negedge clk); csr_en = 0; d = csr_rdata;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); irq_pins[i] = 1'b1;
    @(negedge clk); irq_pins[i] = 1'b0;
  endtask

  task automatic expect_msg(input string req, input int i, input int stall);
    int waited = 0;
    while (!msg_valid && waited < 30) begin @(negedge clk); waited++; end
    check({req, " message present"}, 64'(msg_valid), 64'd1);
    if (msg_valid) begin
      check({req, " device id"}, 64'(msg_dev_id), 64'(dev_of(i)));
      check({req, " event id"}, 64'(msg_event_id), 64'(evt_model[i]));
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check("R9 held payload", {43'd0, msg_valid, msg_dev_id, msg_event_id},
              {43'd0, 1'b1, dev_of(i), evt_model[i]});
      end
      msg_ready = 1'b1;
      @(negedge clk); msg_ready = 1'b0;
    end
  endtask

  task automatic expect_none(input string req, input int n);
    logic seen = 1'b0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    check({req, " no message"}, 64'(seen), 64'd0);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired (R1..R10 run incomplete): actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int order [4];
    for (int i = 0; i < NP; i++) evt_model[i] = 10'(i % 128);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R9 idle after reset", 64'(msg_valid), 64'd0);
    check("R9 doorbell", msg_addr, DBELL);
    csr_rd(16'hA008, d); check("R7 reset pending", 64'(d), 64'd0);
    csr_rd(16'h1000, d); check("R3 reset type", 64'(d), 64'd0);

    // R1: vector register layout and reset values
    for (int i = 0; i < NP; i++) begin
      csr_rd(vec_a(i), d);
      check("R1 vector reset", 64'(d), 64'({10'd0, evt_model[i], dev_of(i)}));
    end

    // R2: only the event ID is writable
    for (int i = 0; i < NP; i++) begin
      logic [9:0] ne = 10'((i*7 + 3) & 'h3FF);
      csr_wr(vec_a(i), 32'hFFC0_0FFF | (32'(ne) << 12));
      evt_model[i] = ne;
      csr_rd(vec_a(i), d);
      check("R2 vector write", 64'(d), 64'({10'd0, ne, dev_of(i)}));
    end

    // R3: type words read back
    for (int n = 1; n <= NODES; n++) begin
      for (int w = 0; w < 4; w++) begin
        logic [31:0] pat = 32'hA5C3_1E00 ^ 32'(n << 8) ^ 32'(w);
        csr_wr(16'(n*4096 + w*4), pat);
        csr_rd(16'(n*4096 + w*4), d); check("R3 type readback", 64'(d), 64'(pat));
        csr_wr(16'(n*4096 + w*4), 32'd0);
        csr_rd(16'(n*4096 + w*4), d); check("R3 type restore", 64'(d), 64'd0);
      end
    end

    // R10: unmapped addresses
    begin
      logic [15:0] un [8] = '{16'h0000, 16'h0200, 16'h3000, 16'h3204,
                              16'h1100, 16'h1010, 16'h1400, 16'hA028};
      foreach (un[k]) begin
        csr_wr(un[k], 32'hFFFF_FFFF);
        csr_rd(un[k], d); check("R10 unmapped read", 64'(d), 64'd0);
      end
      csr_rd(16'h1000, d); check("R10 type untouched", 64'(d), 64'd0);
      csr_rd(vec_a(0), d);
      check("R10 vector untouched", 64'(d), 64'({10'd0, evt_model[0], dev_of(0)}));
      expect_none("R10", 4);
    end

    // R7: reserved pins in the clear page
    csr_wr(16'hA000, 32'hFFFF_FFFF);
    csr_rd(16'hA000, d); check("R7 reserved word 0", 64'(d), 64'd0);
    csr_rd(16'hA004, d); check("R7 reserved word 1", 64'(d), 64'd0);

    // R4 / R6 / R7 / R9: every pin, edge mode
    for (int i = 0; i < NP; i++) begin
      pulse(i);
      expect_msg("R4 edge", i, i % 3);
      csr_rd(clr_a(i), d); check("R7 pending set", 64'(d & clr_bit(i)), 64'(clr_bit(i)));
      pulse(i);
      expect_none("R6 repeat trigger", 4);
      csr_wr(clr_a(i), ~clr_bit(i));
      csr_rd(clr_a(i), d); check("R7 zero write keeps", 64'(d & clr_bit(i)), 64'(clr_bit(i)));
      csr_wr(clr_a(i), clr_bit(i));
      csr_rd(clr_a(i), d); check("R7 cleared", 64'(d & clr_bit(i)), 64'd0);
    end

    // R4: edge pin held high through its clear
    @(negedge clk); irq_pins[10] = 1'b1;
    expect_msg("R4 held", 10, 0);
    csr_wr(clr_a(10), clr_bit(10));
    expect_none("R4 held high", 8);
    csr_rd(clr_a(10), d); check("R4 not re-pending", 64'(d & clr_bit(10)), 64'd0);
    @(negedge clk); irq_pins[10] = 1'b0;

    // R5: level pins in both nodes
    foreach (order[k]) order[k] = 0;
    for (int t = 0; t < 2; t++) begin
      int i = (t == 0) ? 40 : 170;
      csr_wr(type_a(i), 32'(1) << ((i % 128) % 32));
      @(negedge clk); irq_pins[i] = 1'b1;
      expect_msg("R5 level", i, 1);
      csr_wr(clr_a(i), clr_bit(i));
      expect_msg("R5 level after clear", i, 0);
      @(negedge clk); irq_pins[i] = 1'b0;
      csr_wr(clr_a(i), clr_bit(i));
      expect_none("R5 level low", 6);
      csr_rd(clr_a(i), d); check("R5 level released", 64'(d & clr_bit(i)), 64'd0);
      csr_wr(type_a(i), 32'd0);
    end

    // R8: simultaneous triggers
    order = '{5, 77, 130, 200};
    @(negedge clk);
    irq_pins[200] = 1'b1; irq_pins[5] = 1'b1; irq_pins[130] = 1'b1; irq_pins[77] = 1'b1;
    @(negedge clk);
    irq_pins[200] = 1'b0; irq_pins[5] = 1'b0; irq_pins[130] = 1'b0; irq_pins[77] = 1'b0;
    foreach (order[k]) expect_msg("R8 order", order[k], k);
    expect_none("R8 drained", 4);
    for (int w = 2; w < 2 + NP/32; w++) csr_wr(16'('hA000 + w*4), 32'hFFFF_FFFF);
    csr_rd(16'hA008, d); check("R7 bulk clear", 64'(d), 64'd0);
    check("R9 doorbell end", msg_addr, DBELL);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule